// File: doc/BRIEF.md
# Start-Up Enable Qualifier

This block decides when a power controller is allowed to run and when it must stop. It takes six asynchronous digital flags: supply above its under-voltage threshold, reference good, die temperature acceptable, over-voltage clear, the enable level, and a flag showing that the soft-start voltage has passed its early threshold. It produces a run signal that releases the gate outputs and starts the soft-start charge. It also produces the inverse of run, which holds the soft-start node at ground.

Every flag passes through a two-flop synchroniser before any decision is made. The reference flag must stay good for a programmable number of clock cycles before it counts. An enable high shorter than a programmable width is treated as noise. Each start is classified while the controller runs. If the enable falls before the soft-start flag has risen, the start was a pulse, and the next valid rising edge turns the controller off. If the enable falls after that flag has risen, the start was a level, and a sustained low turns the controller off after a programmable delay.

Losing any start condition while running stops the controller at once. It also forgets the level or pulse classification, so the next start is classified afresh.

Top module: `startup_enable_gate`

## Requirements
- R1: Run may go high only while all four conditions hold: supply OK, reference qualified, temperature OK and over-voltage clear. Each condition is active high.
- R2: The reference counts as qualified only after it has been sampled good for REF_QUAL_CYC consecutive cycles. Run rises 2+REF_QUAL_CYC clock edges after the reference input rises, provided the enable is already held. Any drop of the reference restarts the window from zero.
- R3: An enable high counts as valid only if it lasts at least EN_MIN_HIGH_CYC cycles, and shorter highs are ignored. From the idle state, with all conditions met, run rises 2+EN_MIN_HIGH_CYC edges after the enable rises.
- R4: If the enable falls while the soft-start flag is high, the start is a level start. Run falls 2+EN_LOW_CYC edges after the enable falls.
- R5: In a level start, an enable low lasting fewer than EN_LOW_CYC cycles leaves run high.
- R6: If the enable falls while the soft-start flag is low, the start is a pulse start, and run stays high while the enable stays low.
- R7: In a pulse start, a valid enable high turns run off 2+EN_MIN_HIGH_CYC edges after it begins, and a shorter high is ignored. A new start then needs the enable to go low and then high again.
- R8: If any start condition is lost while running, run falls 3 edges after the input changes. The level or pulse classification is cleared, so the next start is classified anew.
- R9: The discharge output is always the inverse of run. During reset, run is low and discharge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvloOkIn | input | 1 | Supply above under-voltage threshold (async) |
| refGoodIn | input | 1 | Reference voltage good (async) |
| tempOkIn | input | 1 | Die temperature below shutdown limit (async) |
| ovpClearIn | input | 1 | Over-voltage input clear (async) |
| enIn | input | 1 | Enable level or pulse input (async) |
| ssAboveIn | input | 1 | Soft-start above its early threshold (async) |
| runOut | output | 1 | Controller running: soft-start charges and outputs are released |
| ssDischargeOut | output | 1 | Hold soft-start at ground |

## Verification
Every result of this block arrives a fixed number of edges after its stimulus:
- Two synchroniser edges come first.
- The qualification counters add their programmed counts. Starts land at 2+REF_QUAL_CYC or 2+EN_MIN_HIGH_CYC edges, and a level shutdown lands at 2+EN_LOW_CYC edges.
- The state register adds one more edge, so a lost condition lands at 3 edges.

The bench drives inputs on falling edges and counts rising edges from the change. It checks the output one edge before each deadline and again at the deadline, which pins down both the count and its direction. Ignored events, such as short highs and short lows, are checked by holding the stimulus and confirming that run keeps its value well past the longest deadline.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RUN_UNDET = 3'd1,
    ST_RUN_LEVEL = 3'd2,
    ST_RUN_PULSE = 3'd3,
    ST_OFF_HOLD  = 3'd4
  } runState_t;

  // Strobes from the qualification datapath to the sequencing control.
  typedef struct packed {
    logic startOk;
    logic enLevel;
    logic enHeld;
    logic enRiseValid;
    logic enFell;
    logic enLowExpired;
    logic ssAbove;
  } qualStrobe_t;

endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i]  <= 1'b0;
        syncOut[i] <= 1'b0;
      end else begin
        stage1[i]  <= asyncIn[i];
        syncOut[i] <= stage1[i];
      end
    end
  end

endmodule

// File: rtl/seg_span_counter.sv
// Reports when a level has been present for LIMIT consecutive samples.
module seg_span_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic held
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!level) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign held = level && (cnt == LAST);

  // A span can complete only after the level was already present one cycle earlier.
  if (LIMIT > 1) begin : g_chk
    assert_span_continuous_R2: assert property (@(posedge clk) disable iff (!rst_n)
      held |-> $past(level));
  end

endmodule

// File: rtl/seg_qualify.sv
module seg_qualify
  import seg_pkg::*;
#(
  parameter int REF_QUAL_CYC    = 2000,
  parameter int EN_MIN_HIGH_CYC = 300,
  parameter int EN_LOW_CYC      = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        uvloS,
  input  logic        refS,
  input  logic        tempS,
  input  logic        ovpS,
  input  logic        enS,
  input  logic        ssS,
  output qualStrobe_t strobe
);

  logic refQual;
  logic enHeld;
  logic enLowHeld;
  logic enDly;
  logic heldPrev;

  seg_span_counter #(.LIMIT(REF_QUAL_CYC)) u_refSpan (
    .clk(clk), .rst_n(rst_n), .level(refS), .held(refQual)
  );

  seg_span_counter #(.LIMIT(EN_MIN_HIGH_CYC)) u_enHighSpan (
    .clk(clk), .rst_n(rst_n), .level(enS), .held(enHeld)
  );

  seg_span_counter #(.LIMIT(EN_LOW_CYC)) u_enLowSpan (
    .clk(clk), .rst_n(rst_n), .level(!enS), .held(enLowHeld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enDly    <= 1'b0;
      heldPrev <= 1'b0;
    end else begin
      enDly    <= enS;
      heldPrev <= enHeld;
    end
  end

  always_comb begin
    strobe.startOk      = uvloS && refQual && tempS && ovpS;
    strobe.enLevel      = enS;
    strobe.enHeld       = enHeld;
    strobe.enRiseValid  = enHeld && !heldPrev;
    strobe.enFell       = enDly && !enS;
    strobe.enLowExpired = enLowHeld;
    strobe.ssAbove      = ssS;
  end

  // A valid rise is a single-cycle event per high period.
  assert_rise_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enRiseValid |=> !strobe.enRiseValid);

  // A valid rise never coincides with a falling edge.
  assert_rise_fall_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.enRiseValid && strobe.enFell));

endmodule

// File: rtl/seg_control.sv
module seg_control
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  qualStrobe_t strobe,
  output logic        running
);

  runState_t state;
  runState_t stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (strobe.startOk && strobe.enHeld) stateNext = ST_RUN_UNDET;
      end
      ST_RUN_UNDET: begin
        if (!strobe.startOk)     stateNext = ST_IDLE;
        else if (strobe.enFell)  stateNext = strobe.ssAbove ? ST_RUN_LEVEL : ST_RUN_PULSE;
      end
      ST_RUN_LEVEL: begin
        if (!strobe.startOk || strobe.enLowExpired) stateNext = ST_IDLE;
      end
      ST_RUN_PULSE: begin
        if (!strobe.startOk)          stateNext = ST_IDLE;
        else if (strobe.enRiseValid)  stateNext = ST_OFF_HOLD;
      end
      ST_OFF_HOLD: begin
        if (!strobe.enLevel) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= (stateNext == ST_RUN_UNDET) || (stateNext == ST_RUN_LEVEL) ||
                           (stateNext == ST_RUN_PULSE);
  end

  assert_start_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(strobe.startOk && strobe.enHeld));

  assert_fault_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !strobe.startOk) |=> !running);

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_LEVEL && strobe.startOk && !strobe.enLowExpired) |=> running);

  assert_pulse_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_UNDET && strobe.startOk && strobe.enFell && !strobe.ssAbove)
      |=> (state == ST_RUN_PULSE));

  assert_pulse_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN_PULSE && strobe.startOk && strobe.enRiseValid) |=> !running);

endmodule

// File: rtl/startup_enable_gate.sv
module startup_enable_gate
  import seg_pkg::*;
#(
  parameter int REF_QUAL_CYC    = 2000,
  parameter int EN_MIN_HIGH_CYC = 300,
  parameter int EN_LOW_CYC      = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvloOkIn,
  input  logic refGoodIn,
  input  logic tempOkIn,
  input  logic ovpClearIn,
  input  logic enIn,
  input  logic ssAboveIn,
  output logic runOut,
  output logic ssDischargeOut
);

  localparam int NUM_FLAGS = 6;

  logic [NUM_FLAGS-1:0] flagsSync;
  qualStrobe_t          strobe;
  logic                 running;

  seg_sync #(.WIDTH(NUM_FLAGS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({ssAboveIn, enIn, ovpClearIn, tempOkIn, refGoodIn, uvloOkIn}),
    .syncOut (flagsSync)
  );

  seg_qualify #(
    .REF_QUAL_CYC    (REF_QUAL_CYC),
    .EN_MIN_HIGH_CYC (EN_MIN_HIGH_CYC),
    .EN_LOW_CYC      (EN_LOW_CYC)
  ) u_qualify (
    .clk    (clk),
    .rst_n  (rst_n),
    .uvloS  (flagsSync[0]),
    .refS   (flagsSync[1]),
    .tempS  (flagsSync[2]),
    .ovpS   (flagsSync[3]),
    .enS    (flagsSync[4]),
    .ssS    (flagsSync[5]),
    .strobe (strobe)
  );

  seg_control u_control (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .running (running)
  );

  assign runOut         = running;
  assign ssDischargeOut = !running;

endmodule

// File: tb/startup_enable_gate_tb_top.sv
module startup_enable_gate_tb_top;

  localparam int REFQ  = 6;
  localparam int MINHI = 4;
  localparam int LOWD  = 5;

  // Row layout: {uvlo, ref, temp, ovp, expected run}
  localparam int NVEC = 8;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1111_1, 5'b0111_0, 5'b1011_0, 5'b1101_0,
    5'b1110_0, 5'b0000_0, 5'b1111_1, 5'b1100_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvloOkIn = 1'b0, refGoodIn = 1'b0, tempOkIn = 1'b0, ovpClearIn = 1'b0;
  logic enIn = 1'b0, ssAboveIn = 1'b0;
  logic runOut, ssDischargeOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  startup_enable_gate #(
    .REF_QUAL_CYC(REFQ), .EN_MIN_HIGH_CYC(MINHI), .EN_LOW_CYC(LOWD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .uvloOkIn(uvloOkIn), .refGoodIn(refGoodIn),
    .tempOkIn(tempOkIn), .ovpClearIn(ovpClearIn), .enIn(enIn), .ssAboveIn(ssAboveIn),
    .runOut(runOut), .ssDischargeOut(ssDischargeOut)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkRun(input string tag, input logic exp);
    testsRun++;
    if (runOut !== exp) begin
      testsFailed++;
      $display("FAIL %s: runOut actual=%b expected=%b", tag, runOut, exp);
    end
    testsRun++;
    if (ssDischargeOut !== !exp) begin
      testsFailed++;
      $display("FAIL R9 %s: ssDischargeOut actual=%b expected=%b", tag, ssDischargeOut, !exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    checkRun("R9 during reset", 1'b0);
    rst_n = 1'b1;

    // R1: condition table walk with the enable held high throughout
    enIn = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      {uvloOkIn, refGoodIn, tempOkIn, ovpClearIn} = VEC[i][4:1];
      tick(REFQ + 10);
      checkRun($sformatf("R1 row %0d", i), VEC[i][0]);
    end

    // R2: reference qualification window
    uvloOkIn = 1'b1; tempOkIn = 1'b1; ovpClearIn = 1'b1; refGoodIn = 1'b0;
    tick(5);
    refGoodIn = 1'b1;
    tick(1 + REFQ);
    checkRun("R2 one edge before window end", 1'b0);
    tick(1);
    checkRun("R2 at window end", 1'b1);

    // R2/R8: single-cycle reference dip restarts the window
    refGoodIn = 1'b0;
    tick(1);
    refGoodIn = 1'b1;
    tick(1);
    checkRun("R8 two edges after dip", 1'b1);
    tick(1);
    checkRun("R8 three edges after dip", 1'b0);
    tick(REFQ - 1);
    checkRun("R2 restarted window not yet done", 1'b0);
    tick(1);
    checkRun("R2 restarted window done", 1'b1);

    // R4: level shutdown after soft-start flag is high
    ssAboveIn = 1'b1;
    tick(4);
    enIn = 1'b0;
    tick(1 + LOWD);
    checkRun("R4 before low delay", 1'b1);
    tick(1);
    checkRun("R4 at low delay", 1'b0);

    // R3: start latency from idle
    enIn = 1'b1;
    tick(1 + MINHI);
    checkRun("R3 before valid width", 1'b0);
    tick(1);
    checkRun("R3 at valid width", 1'b1);

    // R5: short low ignored in level mode
    enIn = 1'b0;
    tick(LOWD - 1);
    enIn = 1'b1;
    tick(15);
    checkRun("R5 short low ignored", 1'b1);

    enIn = 1'b0;
    tick(LOWD + 5);
    checkRun("R4 level off", 1'b0);
    ssAboveIn = 1'b0;
    tick(4);

    // R3: short high ignored from idle
    enIn = 1'b1;
    tick(MINHI - 1);
    enIn = 1'b0;
    tick(15);
    checkRun("R3 short high ignored", 1'b0);

    // R3/R6: exact minimum-width pulse starts and is classified as pulse
    enIn = 1'b1;
    tick(MINHI);
    enIn = 1'b0;
    tick(2);
    checkRun("R3 minimum-width pulse starts", 1'b1);
    tick(20);
    checkRun("R6 pulse start stays on with enable low", 1'b1);
    ssAboveIn = 1'b1;
    tick(4);

    // R7: short high ignored, valid high stops, held high does not restart
    enIn = 1'b1;
    tick(MINHI - 1);
    enIn = 1'b0;
    tick(10);
    checkRun("R7 short high ignored in pulse mode", 1'b1);
    enIn = 1'b1;
    tick(1 + MINHI);
    checkRun("R7 before valid off edge", 1'b1);
    tick(1);
    checkRun("R7 at valid off edge", 1'b0);
    tick(20);
    checkRun("R7 no restart while enable stays high", 1'b0);
    enIn = 1'b0;
    ssAboveIn = 1'b0;
    tick(5);
    enIn = 1'b1;
    tick(2 + MINHI);
    checkRun("R7 restart after low then high", 1'b1);

    // R8: fault in pulse mode clears classification
    enIn = 1'b0;
    tick(10);
    checkRun("R6 pulse mode again", 1'b1);
    ovpClearIn = 1'b0;
    tick(2);
    checkRun("R8 two edges after fault", 1'b1);
    tick(1);
    checkRun("R8 three edges after fault", 1'b0);
    ovpClearIn = 1'b1;
    tick(10);
    checkRun("R8 stays off with enable low", 1'b0);
    enIn = 1'b1;
    tick(2 + MINHI);
    checkRun("R8 restart", 1'b1);
    ssAboveIn = 1'b1;
    tick(4);
    enIn = 1'b0;
    tick(2 + LOWD);
    checkRun("R8 reclassified as level start", 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule